// File: doc/BRIEF.md
# PCI Configuration Identity and Command Register

This block holds the identity dword and the 16-bit command register of a PCI function's configuration header. System software reaches it through a simple dword-addressed configuration port with a read strobe, a write strobe and byte enables. Read data comes back one clock after the read strobe. The block drives the enables that gate the function's I/O decode, memory decode and bus mastering. It also holds the fast back-to-back permission. It turns address-phase and data-phase parity error detect pulses into SERR# and PERR# pulses, each gated by its own command bit.

Most command bits are fixed at zero. Only the I/O, memory, bus-master, parity-response and system-error bits are always writable. The fast back-to-back bit can be written only while an external strap input is high. Bus timing, BAR decode, the status register and parity generation live elsewhere. Parity errors arrive here as single-cycle detect pulses.

Top module: `pci_cmd_cfg`

## Requirements
- R1: A read of dword 0 returns the device ID in bits 31:16 (default 16'h8139) and the vendor ID in bits 15:0 (default 16'h10EC). Writes to dword 0 change nothing.
- R2: In a read of dword 1, bits 15:10 of the command word are always 0, whatever was written.
- R3: Command bits 3 (special cycles), 4 (memory write and invalidate), 5 (palette snoop) and 7 (stepping) always read 0 and ignore writes.
- R4: Command bit 9 (fast back-to-back) follows writes only while `fbb_option` is 1. While `fbb_option` is 0 the bit reads 0 and ignores writes. If the option drops, the bit is 0 from the next clock. `fast_b2b_en` shows the bit.
- R5: An `addr_par_err` pulse drives `serr_n` low in the next cycle only when command bit 8 is 1. Otherwise `serr_n` stays high.
- R6: A `data_par_err` pulse drives `perr_n` low in the next cycle only when command bit 6 is 1. Otherwise `perr_n` stays high and nothing else changes.
- R7: `io_space_en`, `mem_space_en` and `bus_master_en` equal command bits 0, 1 and 2, and they update on the clock after the write.
- R8: Reset clears every writable command bit, so all enables are 0, `serr_n` and `perr_n` are 1, and no read data is valid.
- R9: `cfg_be[0]` gates writes to command bits 7:0 and `cfg_be[1]` gates writes to bits 15:8. A byte whose enable is 0 keeps its value.
- R10: Writes to any dword other than 1 leave the command word unchanged. Reads of any dword other than 0 and 1 return 0.
- R11: `cfg_rvalid` is high for exactly the one cycle after each read strobe. Each SERR# or PERR# assertion lasts exactly one cycle per detect pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req_wr | input | 1 | Configuration write strobe |
| cfg_req_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Dword index within the header |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| fbb_option | input | 1 | Strap that allows the fast back-to-back bit to be written |
| addr_par_err | input | 1 | Address-phase parity error detect pulse |
| data_par_err | input | 1 | Data-phase parity error detect pulse (as target) |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| cfg_rdata | output | 32 | Read data |
| io_space_en | output | 1 | I/O space decode enable |
| mem_space_en | output | 1 | Memory space decode enable |
| bus_master_en | output | 1 | Bus mastering permitted |
| fast_b2b_en | output | 1 | Fast back-to-back transactions permitted |
| serr_n | output | 1 | System error, active low |
| perr_n | output | 1 | Data parity error, active low |

## Verification
The command word is written with all ones, with single-byte enables, and with one enable bit at a time. This separates the writable bits from the fixed-zero bits and from the byte gating. The fast back-to-back bit is written with the strap low, with the strap high, and after the strap falls, so a strap that is ignored or latched shows up. Every combination of the two reporting bits is paired with address-only, data-only and simultaneous parity pulses. This tells a swapped gate or a crossed output apart from a correct one, and checks the one-cycle pulse width. Writes and reads to other dwords and a reset in mid-run cover the decode and the reset paths.

// File: rtl/pci_cmd_pkg.sv
package pci_cmd_pkg;
    localparam int CMD_W   = 16;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;

    // command bit positions (standard header layout)
    localparam int B_IO    = 0;
    localparam int B_MEM   = 1;
    localparam int B_MST   = 2;
    localparam int B_SPC   = 3;
    localparam int B_MWI   = 4;
    localparam int B_SNP   = 5;
    localparam int B_PRSP  = 6;
    localparam int B_STEP  = 7;
    localparam int B_SERR  = 8;
    localparam int B_FBB   = 9;

    localparam logic [CMD_W-1:0] BASE_MASK =
        CMD_W'((1 << B_IO) | (1 << B_MEM) | (1 << B_MST) | (1 << B_PRSP) | (1 << B_SERR));
    localparam logic [CMD_W-1:0] FBB_MASK = CMD_W'(1 << B_FBB);

    // dword indices
    localparam int ID_DW  = 0;
    localparam int CMD_DW = 1;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
    } cmd_st_t;

    typedef struct packed {
        logic serr;
        logic perr;
    } err_st_t;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rd_st_t;
endpackage

// File: rtl/pci_cmd_regs.sv
module pci_cmd_regs
    import pci_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_be,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             fbb_option,
    output logic [CMD_W-1:0] cmd_q
);
    cmd_st_t s_d, s_q;
    logic [CMD_W-1:0] wmask;

    always_comb begin
        wmask = BASE_MASK | (fbb_option ? FBB_MASK : '0);
        s_d   = s_q;
        if (wr_en) begin
            for (int b = 0; b < 2; b++) begin
                if (wr_be[b]) begin
                    s_d.cmd[b*8 +: 8] = wr_data[b*8 +: 8] & wmask[b*8 +: 8];
                end
            end
        end
        if (!fbb_option) begin
            s_d.cmd[B_FBB] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_q = s_q.cmd;
endmodule

// File: rtl/pci_par_report.sv
module pci_par_report
    import pci_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic serr_allow,
    input  logic perr_allow,
    input  logic addr_par_err,
    input  logic data_par_err,
    output logic serr_n,
    output logic perr_n
);
    err_st_t s_d, s_q;

    always_comb begin
        s_d.serr = addr_par_err & serr_allow;
        s_d.perr = data_par_err & perr_allow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign serr_n = ~s_q.serr;
    assign perr_n = ~s_q.perr;
endmodule

// File: rtl/pci_cfg_rdport.sv
module pci_cfg_rdport
    import pci_cmd_pkg::*;
#(
    parameter int              ADDR_W    = 6,
    parameter logic [15:0]     VENDOR_ID = 16'h10EC,
    parameter logic [15:0]     DEVICE_ID = 16'h8139
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CMD_W-1:0]  cmd_q,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    rd_st_t s_d, s_q;

    always_comb begin
        s_d.vld  = rd_req;
        s_d.data = s_q.data;
        if (rd_req) begin
            if (rd_addr == ADDR_W'(ID_DW))
                s_d.data = {DEVICE_ID, VENDOR_ID};
            else if (rd_addr == ADDR_W'(CMD_DW))
                s_d.data = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
            else
                s_d.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rvalid = s_q.vld;
    assign rdata  = s_q.data;
endmodule

// File: rtl/pci_cmd_cfg.sv
module pci_cmd_cfg
    import pci_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] VENDOR_ID = 16'h10EC,
    parameter logic [15:0] DEVICE_ID = 16'h8139
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req_wr,
    input  logic              cfg_req_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [3:0]        cfg_be,
    input  logic              fbb_option,
    input  logic              addr_par_err,
    input  logic              data_par_err,
    output logic              cfg_rvalid,
    output logic [31:0]       cfg_rdata,
    output logic              io_space_en,
    output logic              mem_space_en,
    output logic              bus_master_en,
    output logic              fast_b2b_en,
    output logic              serr_n,
    output logic              perr_n
);
    logic [CMD_W-1:0] cmd_q;
    logic             cmd_wr;
    logic             unused_hi;

    // upper half of the dword belongs to the status register, handled elsewhere
    assign unused_hi = ^{cfg_wdata[31:16], cfg_be[3:2]};
    assign cmd_wr    = cfg_req_wr && (cfg_addr == ADDR_W'(CMD_DW));

    pci_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cmd_wr),
        .wr_be      (cfg_be[1:0]),
        .wr_data    (cfg_wdata[15:0]),
        .fbb_option (fbb_option),
        .cmd_q      (cmd_q)
    );

    pci_par_report u_par (
        .clk          (clk),
        .rst_n        (rst_n),
        .serr_allow   (cmd_q[B_SERR]),
        .perr_allow   (cmd_q[B_PRSP]),
        .addr_par_err (addr_par_err),
        .data_par_err (data_par_err),
        .serr_n       (serr_n),
        .perr_n       (perr_n)
    );

    pci_cfg_rdport #(
        .ADDR_W    (ADDR_W),
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (cfg_req_rd),
        .rd_addr (cfg_addr),
        .cmd_q   (cmd_q),
        .rvalid  (cfg_rvalid),
        .rdata   (cfg_rdata)
    );

    assign io_space_en   = cmd_q[B_IO];
    assign mem_space_en  = cmd_q[B_MEM];
    assign bus_master_en = cmd_q[B_MST];
    assign fast_b2b_en   = cmd_q[B_FBB];
endmodule

// File: rtl/pci_cmd_cfg_chk.sv
module pci_cmd_cfg_chk
    import pci_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] VENDOR_ID = 16'h10EC,
    parameter logic [15:0] DEVICE_ID = 16'h8139
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_req_rd,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_rvalid,
    input logic [31:0]       cfg_rdata,
    input logic              fbb_option,
    input logic              fast_b2b_en,
    input logic              addr_par_err,
    input logic              data_par_err,
    input logic              serr_n,
    input logic              perr_n,
    input logic [CMD_W-1:0]  cmd_q
);
    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid && $past(cfg_addr) == ADDR_W'(ID_DW) |-> cfg_rdata == {DEVICE_ID, VENDOR_ID}); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid && $past(cfg_addr) == ADDR_W'(CMD_DW) |-> cfg_rdata[15:10] == 6'd0); // R2

    AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid && $past(cfg_addr) == ADDR_W'(CMD_DW)
        |-> !cfg_rdata[B_SPC] && !cfg_rdata[B_MWI] && !cfg_rdata[B_SNP] && !cfg_rdata[B_STEP]); // R3

    AST_FBB_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !fbb_option |=> !fast_b2b_en); // R4

    AST_SERR_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_par_err && cmd_q[B_SERR] |=> !serr_n); // R5

    AST_SERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_par_err && cmd_q[B_SERR]) |=> serr_n); // R5

    AST_PERR_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        data_par_err && cmd_q[B_PRSP] |=> !perr_n); // R6

    AST_PERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_par_err && cmd_q[B_PRSP]) |=> perr_n); // R6

    AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_rd |=> cfg_rvalid); // R11

    AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req_rd |=> !cfg_rvalid); // R11
endmodule

bind pci_cmd_cfg pci_cmd_cfg_chk #(
    .ADDR_W    (ADDR_W),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_req_rd   (cfg_req_rd),
    .cfg_addr     (cfg_addr),
    .cfg_rvalid   (cfg_rvalid),
    .cfg_rdata    (cfg_rdata),
    .fbb_option   (fbb_option),
    .fast_b2b_en  (fast_b2b_en),
    .addr_par_err (addr_par_err),
    .data_par_err (data_par_err),
    .serr_n       (serr_n),
    .perr_n       (perr_n),
    .cmd_q        (cmd_q)
);

// File: tb/sim_pci_cmd_cfg.sv
module sim_pci_cmd_cfg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_req_wr, cfg_req_rd;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [3:0]  cfg_be;
    logic        fbb_option, addr_par_err, data_par_err;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        io_space_en, mem_space_en, bus_master_en, fast_b2b_en, serr_n, perr_n;

    always #5 clk = ~clk;

    pci_cmd_cfg u0 (.*);

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_cmd;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares read returns against the scoreboard
    always @(negedge clk) begin
        if (rst_n && cfg_rvalid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R11 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(cfg_rdata === e.exp, e.req, cfg_rdata, e.exp);
            end
        end
    end

    function automatic logic [15:0] apply_wr(logic [15:0] cur, logic [15:0] d, logic [1:0] be, logic opt);
        logic [15:0] mask, nxt;
        mask = 16'h0147 | (opt ? 16'h0200 : 16'h0000);
        nxt  = cur;
        if (be[0]) nxt[7:0]  = d[7:0]  & mask[7:0];
        if (be[1]) nxt[15:8] = d[15:8] & mask[15:8];
        if (!opt)  nxt[9] = 1'b0;
        return nxt;
    endfunction

    task automatic do_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_req_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_req_wr = 1'b0; cfg_be = 4'h0;
        if (a == 6'd1) m_cmd = apply_wr(m_cmd, d[15:0], be[1:0], fbb_option);
    endtask

    task automatic do_read(input logic [5:0] a, input logic [31:0] exp, input string req);
        exp_t e;
        @(negedge clk);
        cfg_req_rd = 1'b1; cfg_addr = a;
        e.exp = exp; e.req = req;
        sbq.push_back(e);
        @(negedge clk);
        cfg_req_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_en(input string req);
        chk(io_space_en === m_cmd[0], {req, " io"}, 32'(io_space_en), 32'(m_cmd[0]));
        chk(mem_space_en === m_cmd[1], {req, " mem"}, 32'(mem_space_en), 32'(m_cmd[1]));
        chk(bus_master_en === m_cmd[2], {req, " master"}, 32'(bus_master_en), 32'(m_cmd[2]));
        chk(fast_b2b_en === m_cmd[9], {req, " fbb"}, 32'(fast_b2b_en), 32'(m_cmd[9]));
    endtask

    task automatic par_pulse(input logic a, input logic d);
        logic es, ep;
        @(negedge clk);
        addr_par_err = a; data_par_err = d;
        @(negedge clk);
        addr_par_err = 1'b0; data_par_err = 1'b0;
        es = !(a && m_cmd[8]);
        ep = !(d && m_cmd[6]);
        chk(serr_n === es, "R5 serr_n", 32'(serr_n), 32'(es));
        chk(perr_n === ep, "R6 perr_n", 32'(perr_n), 32'(ep));
        @(negedge clk);
        chk(serr_n === 1'b1, "R11 serr one cycle", 32'(serr_n), 32'd1);
        chk(perr_n === 1'b1, "R11 perr one cycle", 32'(perr_n), 32'd1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cmd = 16'h0;
        sbq.delete();
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_req_wr = 1'b0; cfg_req_rd = 1'b0; cfg_addr = '0;
        cfg_wdata = '0; cfg_be = '0; fbb_option = 1'b0;
        addr_par_err = 1'b0; data_par_err = 1'b0; m_cmd = '0;
        do_reset();

        // R8: reset state
        chk_en("R8 reset");
        chk(serr_n === 1'b1 && perr_n === 1'b1, "R8 err idle", {30'd0, serr_n, perr_n}, 32'd3);
        chk(cfg_rvalid === 1'b0, "R8 rvalid", 32'(cfg_rvalid), 32'd0);
        do_read(6'd1, 32'h0, "R8 cmd after reset");

        // R1: identity, read-only
        do_read(6'd0, 32'h8139_10EC, "R1 id read");
        do_write(6'd0, 32'h0000_0000, 4'hF);
        do_read(6'd0, 32'h8139_10EC, "R1 id after write");

        // R2 R3 R4: all ones with strap low
        do_write(6'd1, 32'h0000_FFFF, 4'h3);
        do_read(6'd1, {16'h0, m_cmd}, "R2 R3 R4 all-ones write");
        chk(m_cmd === 16'h0147, "R3 model", 32'(m_cmd), 32'h147);
        chk_en("R7 all set");

        // R9: byte enables
        do_write(6'd1, 32'h0000_0000, 4'h1);
        do_read(6'd1, {16'h0, m_cmd}, "R9 low byte only");
        do_write(6'd1, 32'h0000_0000, 4'h2);
        do_read(6'd1, {16'h0, m_cmd}, "R9 high byte only");

        // R7: one enable at a time
        for (int i = 0; i < 3; i++) begin
            do_write(6'd1, 32'(1 << i), 4'h3);
            chk_en("R7 single enable");
        end

        // R4: strap high then falling
        @(negedge clk); fbb_option = 1'b1;
        do_write(6'd1, 32'h0000_0200, 4'h2);
        chk_en("R4 fbb writable");
        do_read(6'd1, {16'h0, m_cmd}, "R4 fbb read");
        @(negedge clk); fbb_option = 1'b0;
        @(negedge clk); m_cmd[9] = 1'b0;
        chk_en("R4 strap dropped");
        do_write(6'd1, 32'h0000_0200, 4'h2);
        chk_en("R4 fbb ignored");

        // R10: other dwords
        do_write(6'd1, 32'h0000_0007, 4'h3);
        do_write(6'd2, 32'h0000_FFFF, 4'hF);
        do_write(6'd3, 32'h0000_0000, 4'hF);
        do_read(6'd1, {16'h0, m_cmd}, "R10 cmd untouched");
        do_read(6'd2, 32'h0, "R10 other dword reads 0");
        do_read(6'd5, 32'h0, "R10 other dword reads 0");

        // R5 R6: every enable combination against every pulse pattern
        for (int c = 0; c < 4; c++) begin
            do_write(6'd1, 32'((c[0] ? 16'h0100 : 16'h0) | (c[1] ? 16'h0040 : 16'h0)), 4'h3);
            par_pulse(1'b1, 1'b0);
            par_pulse(1'b0, 1'b1);
            par_pulse(1'b1, 1'b1);
        end

        // R8: reset mid-run
        do_write(6'd1, 32'h0000_0147, 4'h3);
        do_reset();
        chk_en("R8 mid-run reset");
        par_pulse(1'b1, 1'b1);
        do_read(6'd1, 32'h0, "R8 cmd after mid-run reset");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R11 read returns outstanding", 32'(sbq.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule